// File: doc/BRIEF.md
# PCI Interrupt Line Router

The block steers four shared PCI interrupt request lines onto sixteen inputs of a legacy interrupt controller. Each request line owns one byte of routing state, which software programs through a byte-addressed configuration window with per-byte write enables and combinational readback. A routing byte below the number of outputs names the controller input the line drives; any larger value leaves the line unrouted.

Internally the router keeps a level matrix with one bit per (output, line) pair. A level change on a routed line updates only that line's bit, while any write that touches a routing byte throws the whole matrix away and rebuilds it from the live line levels under the new routing. Each output is the OR of its row of the matrix. A separate combinational helper turns a device's interrupt pin and device/function number into a request line by slot rotation and reports where that line is currently routed.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads 0x80 and all sixteen outputs are low.
- R2: The routing byte of line n lives at configuration byte offset 0x60+n; a read with cfg_addr[7:2] equal to 0x18 returns line n's byte in bits 8n+7:8n, and a read of any other dword returns zero.
- R3: A write changes only the routing bytes whose byte enable is set (cfg_be bit n covers bits 8n+7:8n), stores all eight bits unchanged, and a write with no enables set changes nothing.
- R4: A line whose routing byte is 16 or more contributes to no output, whatever its level does.
- R5: Output o is high exactly when some line is high and holds a routing byte equal to o, seen one clock after the line level or routing byte takes that value.
- R6: A write that enables any routing byte rebuilds the level state from the current line levels, so a line that was already high appears on its new output one clock after the write.
- R7: With no routing write and no line level change, the outputs hold their value.
- R8: The slot helper returns line ((map_intx + map_devfn[7:3] - 1) mod 4), where map_intx 0 is the first interrupt pin.
- R9: The helper reports map_en=1 and map_irq equal to the selected line's routing byte when that byte is below 16, and map_en=0 with map_irq=0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (bits 7:2 pick the dword) |
| cfg_be | input | 4 | Byte enables for the write lanes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational readback of the addressed dword |
| pirq_lvl | input | 4 | Current levels of the shared request lines |
| irq_out | output | 16 | Interrupt controller inputs |
| map_devfn | input | 8 | Device/function number for the slot helper |
| map_intx | input | 2 | Device interrupt pin, 0 for the first pin |
| map_line | output | 2 | Request line chosen by slot rotation |
| map_en | output | 1 | Selected line is routed |
| map_irq | output | 4 | Output the selected line drives, zero when unrouted |

## Verification
Every cycle the checker confirms that no line occupies more than one matrix row, that an unrouted line holds no matrix bit, that the cycle after reset shows the default routing and silent outputs, and that the outputs do not move without a write or a level change. Whether the right output rises, the rebuild after a partial write with lines already high, byte-lane isolation, the readback layout and the slot rotation arithmetic only show in the bench's sweeps, which compare against a model of routing bytes and levels.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef logic [7:0] route_t;

  localparam route_t ROUTE_RESET = 8'h80;

  // A routing byte is live when it names an existing output.
  function automatic logic route_live(input route_t v, input route_t limit);
    return v < limit;
  endfunction

  // Slot rotation: pin plus device number minus one; caller keeps the low bits.
  function automatic logic [7:0] slot_line(input logic [7:0] devfn, input logic [7:0] pin);
    logic [7:0] s;
    s = pin + {3'b000, devfn[7:3]} - 8'd1;
    return s;
  endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter logic [7:0] BASE = 8'h60
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr,
  input  logic [7:0]                cfg_addr,
  input  logic [3:0]                cfg_be,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  output logic [N_LINES-1:0][7:0]   route_q,
  output logic [N_LINES-1:0][7:0]   route_d,
  output logic                      rewrite
);
  logic [N_LINES-1:0]       hit;
  logic [N_LINES-1:0][31:0] lane;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    localparam logic [7:0] LA = BASE + 8'(n);
    logic sel;
    assign sel     = cfg_addr[7:2] == LA[7:2];
    assign hit[n]  = cfg_wr && sel && cfg_be[LA[1:0]];
    assign route_d[n] = hit[n] ? cfg_wdata[LA[1:0]*8 +: 8] : route_q[n];
    assign lane[n] = sel ? (32'(route_q[n]) << (8 * LA[1:0])) : 32'd0;

    always_ff @(posedge clk) begin
      if (rst) route_q[n] <= ROUTE_RESET;
      else     route_q[n] <= route_d[n];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int n = 0; n < N_LINES; n++) cfg_rdata = cfg_rdata | lane[n];
  end

  assign rewrite = |hit;
endmodule

// File: rtl/pirq_level_matrix.sv
module pirq_level_matrix
  import pirq_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int N_OUTS  = 16,
  localparam int OUT_W  = $clog2(N_OUTS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [N_LINES-1:0][7:0]          route_q,
  input  logic [N_LINES-1:0][7:0]          route_d,
  input  logic                             rewrite,
  input  logic [N_LINES-1:0]               lvl_in,
  output logic [N_OUTS-1:0][N_LINES-1:0]   matrix,
  output logic                             level_evt,
  output logic [N_OUTS-1:0]                irq_out
);
  localparam route_t LIMIT = 8'(N_OUTS);

  logic [N_LINES-1:0]             lvl_prev;
  logic [N_OUTS-1:0][N_LINES-1:0] m_nxt;

  assign level_evt = |(lvl_in ^ lvl_prev);

  always_comb begin
    m_nxt = matrix;
    if (rewrite) begin
      m_nxt = '0;
      for (int n = 0; n < N_LINES; n++)
        if (route_live(route_d[n], LIMIT))
          m_nxt[route_d[n][OUT_W-1:0]][n] = lvl_in[n];
    end else begin
      for (int n = 0; n < N_LINES; n++)
        if (lvl_in[n] != lvl_prev[n] && route_live(route_q[n], LIMIT))
          m_nxt[route_q[n][OUT_W-1:0]][n] = lvl_in[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      matrix   <= '0;
      lvl_prev <= '0;
    end else begin
      matrix   <= m_nxt;
      lvl_prev <= lvl_in;
    end
  end

  for (genvar o = 0; o < N_OUTS; o++) begin : g_out
    assign irq_out[o] = |matrix[o];
  end
endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map
  import pirq_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int N_OUTS  = 16,
  localparam int LINE_W = $clog2(N_LINES),
  localparam int OUT_W  = $clog2(N_OUTS)
) (
  input  logic [N_LINES-1:0][7:0] route_q,
  input  logic [7:0]              devfn,
  input  logic [LINE_W-1:0]       intx,
  output logic [LINE_W-1:0]       line,
  output logic                    en,
  output logic [OUT_W-1:0]        irq
);
  localparam route_t LIMIT = 8'(N_OUTS);
  logic [7:0] sum;
  route_t     sel_route;

  assign sum       = slot_line(devfn, 8'(intx));
  assign line      = sum[LINE_W-1:0];
  assign sel_route = route_q[line];
  assign en        = route_live(sel_route, LIMIT);
  assign irq       = en ? sel_route[OUT_W-1:0] : '0;
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int N_OUTS  = 16,
  parameter logic [7:0] BASE = 8'h60,
  localparam int LINE_W = $clog2(N_LINES),
  localparam int OUT_W  = $clog2(N_OUTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [7:0]         cfg_addr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [N_LINES-1:0] pirq_lvl,
  output logic [N_OUTS-1:0]  irq_out,
  input  logic [7:0]         map_devfn,
  input  logic [LINE_W-1:0]  map_intx,
  output logic [LINE_W-1:0]  map_line,
  output logic               map_en,
  output logic [OUT_W-1:0]   map_irq
);
  logic [N_LINES-1:0][7:0]        route_q;
  logic [N_LINES-1:0][7:0]        route_d;
  logic                           rewrite;
  logic                           level_evt;
  logic [N_OUTS-1:0][N_LINES-1:0] matrix;

  pirq_cfg_regs #(.N_LINES(N_LINES), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .route_q(route_q),
    .route_d(route_d), .rewrite(rewrite)
  );

  pirq_level_matrix #(.N_LINES(N_LINES), .N_OUTS(N_OUTS)) u_mat (
    .clk(clk), .rst(rst), .route_q(route_q), .route_d(route_d), .rewrite(rewrite),
    .lvl_in(pirq_lvl), .matrix(matrix), .level_evt(level_evt), .irq_out(irq_out)
  );

  pirq_slot_map #(.N_LINES(N_LINES), .N_OUTS(N_OUTS)) u_map (
    .route_q(route_q), .devfn(map_devfn), .intx(map_intx),
    .line(map_line), .en(map_en), .irq(map_irq)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int N_LINES = 4,
  parameter int N_OUTS  = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           rewrite,
  input logic                           level_evt,
  input logic [N_LINES-1:0][7:0]        route_q,
  input logic [N_OUTS-1:0][N_LINES-1:0] matrix,
  input logic [N_OUTS-1:0]              irq_out
);
  logic [N_LINES-1:0][N_OUTS-1:0] col;

  for (genvar n = 0; n < N_LINES; n++) begin : g_col
    for (genvar o = 0; o < N_OUTS; o++) begin : g_bit
      assign col[n][o] = matrix[o][n];
    end

    // R5: a line drives at most one output row
    a_r5_single_row: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col[n]));

    // R4: an unrouted line holds no level bit
    a_r4_unrouted_silent: assert property (@(posedge clk) disable iff (rst)
      (route_q[n] >= 8'(N_OUTS)) |-> (col[n] == '0));
  end

  // R1: defaults right after reset
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_out == '0 && route_q == {N_LINES{8'h80}}));

  // R7: outputs hold without a routing write or level change
  a_r7_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (!rewrite && !level_evt) |=> $stable(irq_out));
endmodule

bind pirq_router pirq_router_chk #(.N_LINES(N_LINES), .N_OUTS(N_OUTS)) u_chk (
  .clk(clk), .rst(rst), .rewrite(rewrite), .level_evt(level_evt),
  .route_q(route_q), .matrix(matrix), .irq_out(irq_out)
);

// File: tb/pirq_router_test.sv
module pirq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq_lvl = 4'h0;
  logic [15:0] irq_out;
  logic [7:0]  map_devfn = 8'h00;
  logic [1:0]  map_intx = 2'd0;
  logic [1:0]  map_line;
  logic        map_en;
  logic [3:0]  map_irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mroute [4];

  always #4 clk = ~clk;

  pirq_router uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pirq_lvl(pirq_lvl),
    .irq_out(irq_out), .map_devfn(map_devfn), .map_intx(map_intx),
    .map_line(map_line), .map_en(map_en), .map_irq(map_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_out();
    logic [15:0] v = '0;
    for (int n = 0; n < 4; n++)
      if (pirq_lvl[n] && mroute[n] < 8'd16) v[mroute[n][3:0]] = 1'b1;
    return v;
  endfunction

  task automatic write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h60; cfg_be = be; cfg_wdata = d;
    for (int n = 0; n < 4; n++) if (be[n]) mroute[n] = d[8*n +: 8];
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic levels(input logic [3:0] v);
    @(negedge clk);
    pirq_lvl = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int n = 0; n < 4; n++) mroute[n] = 8'h80;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", 32'(irq_out), 32'h0);
    read(8'h60, rd);
    check("R1 routing defaults", rd, 32'h80808080);
    read(8'h63, rd);
    check("R2 byte address inside dword", rd, 32'h80808080);
    read(8'h64, rd);
    check("R2 other dword reads zero", rd, 32'h0);
    read(8'h5c, rd);
    check("R2 dword below reads zero", rd, 32'h0);

    write(4'b0010, 32'hAABBCCDD);
    read(8'h60, rd);
    check("R3 single lane write", rd, 32'h8080CC80);
    write(4'b1000, 32'h11223344);
    read(8'h60, rd);
    check("R3 top lane write", rd, 32'h1180CC80);
    write(4'b0000, 32'h00000000);
    read(8'h60, rd);
    check("R3 write with no enables", rd, 32'h1180CC80);
    write(4'hF, 32'h80808080);

    // R6: lines already high land on new outputs right after the write
    levels(4'b0101);
    check("R4 unrouted lines silent", 32'(irq_out), 32'h0);
    write(4'hF, 32'h03030303);
    check("R6 rebuild from live levels", 32'(irq_out), 32'h0008);
    write(4'b0001, 32'h00000014);
    check("R4 one of two lines unrouted", 32'(irq_out), 32'h0008);
    write(4'b0100, 32'h00090000);
    check("R6 partial rewrite moves line", 32'(irq_out), 32'h0200);
    write(4'b0100, 32'h00100000);
    check("R4 value 16 disables", 32'(irq_out), 32'h0000);
    levels(4'b0000);
    levels(4'b0100);
    check("R4 change on unrouted line ignored", 32'(irq_out), 32'h0000);
    @(negedge clk);
    check("R7 quiet cycle holds", 32'(irq_out), 32'h0000);

    // Sweep of routing patterns against every level combination
    for (int c = 0; c < 64; c++) begin
      logic [31:0] w;
      for (int n = 0; n < 4; n++)
        w[8*n +: 8] = 8'((c * 7 + n * 5 + (c / 3) * n) % 20);
      write(4'hF, w);
      check("R6 sweep rebuild", 32'(irq_out), 32'(model_out()));
      read(8'h60, rd);
      check("R2 sweep readback", rd, w);
      for (int l = 0; l < 16; l++) begin
        levels(4'(l ^ (c & 15)));
        check("R5 sweep output", 32'(irq_out), 32'(model_out()));
      end
      @(negedge clk);
      check("R7 sweep hold", 32'(irq_out), 32'(model_out()));
    end

    // Slot rotation and route query, exhaustive
    write(4'hF, 32'h800F1005);
    for (int d = 0; d < 256; d++) begin
      for (int p = 0; p < 4; p++) begin
        int ln;
        @(negedge clk);
        map_devfn = 8'(d); map_intx = 2'(p);
        #1;
        ln = (p + (d >> 3) + 3) % 4;
        check("R8 slot rotation", 32'(map_line), 32'(ln));
        if (mroute[ln] < 8'd16)
          check("R9 route query", {map_en, map_irq}, {1'b1, mroute[ln][3:0]});
        else
          check("R9 route query off", {map_en, map_irq}, 32'h0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule